// File: doc/BRIEF.md
# Coprocessor Count/Compare Timer with Interrupt Cause Register

This block keeps a free-running counter and a compare value for a processor's system-control coprocessor. The counter advances once for every pulse of a fixed-rate timebase enable. When the counter steps onto the compare value, a timer-pending bit is latched in a cause word. It stays latched until software writes the compare register again, and that write is how the interrupt is acknowledged. The same cause word also mirrors a level-sensitive request line from an external interrupt controller. The block's single interrupt output is the OR of the two pending bits.

Alongside the timer, a small index generator supplies a pseudo-random slot number for translation-buffer replacement. The number counts down once per clock. It never goes below a software-programmed floor, so the entries under that floor are never picked for replacement. Software accesses everything through per-register write strobes, a shared write-data bus and a read-select code with a combinational read-data path.

Top module: `cp0_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, the counter reads 1, compare reads 0, the cause word reads 0, the floor reads 0, the index reads TLB_ENTRIES-1, and `hw_irq` is low.
- R2: The counter increments by one at each clock edge where `tick_en` is high, holds otherwise, and wraps modulo 2^CNT_W.
- R3: A counter write loads `wdata` (it takes priority over a tick) and leaves compare unchanged. A compare write loads `wdata` and does not disturb the counter, which keeps ticking.
- R4: Cause bit 15 is set at the edge where the counter takes a new value equal to compare, whether the change comes from a tick or from a counter write. The bit is not set while the counter stays unchanged, even if it equals compare.
- R5: Any compare write clears cause bit 15 at that edge. If a match occurs in the same cycle, the clear wins.
- R6: Cause bit 10 takes the level of `ext_irq` one clock later. It sets while the line is high and clears after the line falls.
- R7: `hw_irq` is high exactly when cause bit 15 or cause bit 10 is set. All other cause bits read 0.
- R8: The index steps down by one each clock. On a clock where it is at or below the floor, it reloads to TLB_ENTRIES-1 instead, so it always lies between the floor and TLB_ENTRIES-1.
- R9: A floor write reloads the index to TLB_ENTRIES-1 at that edge. A written value greater than TLB_ENTRIES-1 is stored as TLB_ENTRIES-1.
- R10: `rd_sel` chooses the read data: 0 counter, 1 compare, 2 cause, 3 floor, 4 index, each zero-extended. Codes 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Timebase enable, one pulse per counter increment |
| ext_irq | input | 1 | Level request from the external interrupt controller |
| wr_count | input | 1 | Write strobe for the counter |
| wr_compare | input | 1 | Write strobe for compare (also acknowledges the timer) |
| wr_wired | input | 1 | Write strobe for the index floor |
| wdata | input | DATA_W | Write data shared by all strobes |
| rd_sel | input | 3 | Read register select |
| rdata | output | DATA_W | Read data for the selected register |
| hw_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with CNT_W=8 and TLB_ENTRIES=8. The 8-bit counter wraps within a few hundred ticks, so the bench can show a compare value of 2 being reached across the wrap boundary. Eight index slots let the bench program every possible floor value from 0 to 7 and also an out-of-range value. For each floor it follows the index around its full countdown and compares it with an arithmetic model, cycle by cycle.

// File: rtl/cp0t_pkg.sv
package cp0t_pkg;
   typedef enum logic [2:0] {
      SEL_COUNT   = 3'd0,
      SEL_COMPARE = 3'd1,
      SEL_CAUSE   = 3'd2,
      SEL_WIRED   = 3'd3,
      SEL_RANDOM  = 3'd4
   } rd_sel_e;

   localparam int unsigned TIMER_BIT = 15;
   localparam int unsigned EXT_BIT   = 10;
endpackage

// File: rtl/cp0t_count_match.sv
module cp0t_count_match #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_count,
   input  logic             wr_compare,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] compare_q,
   output logic             timer_pend
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("cp0t_count_match: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] count_d;
   logic             hit;

   always_comb begin
      if (wr_count)     count_d = wdata;
      else if (tick_en) count_d = count_q + CNT_ONE;
      else              count_d = count_q;
   end

   assign hit = (count_d != count_q) && (count_d == compare_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q    <= CNT_ONE;
         compare_q  <= '0;
         timer_pend <= 1'b0;
      end else begin
         count_q <= count_d;
         if (wr_compare) compare_q <= wdata;
         if (wr_compare)  timer_pend <= 1'b0;
         else if (hit)    timer_pend <= 1'b1;
      end
   end

   assert_cmp_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_compare |=> !timer_pend);

   assert_count_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_count) |=> $stable(count_q));

   assert_no_stationary_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!timer_pend && !tick_en && !wr_count) |=> !timer_pend);

   assert_compare_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_compare |=> $stable(compare_q));
endmodule

// File: rtl/cp0t_rand_index.sv
module cp0t_rand_index #(
   parameter int ENTRIES = 48,
   parameter int IN_W    = 32,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_wired,
   input  logic [IN_W-1:0]  wdata,
   output logic [IDX_W-1:0] wired_q,
   output logic [IDX_W-1:0] random_q
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("cp0t_rand_index: ENTRIES must be at least 2");
   end
   if (IN_W < IDX_W) begin : g_bad_in_w
      $error("cp0t_rand_index: IN_W narrower than the index");
   end

   logic [IDX_W-1:0] wired_in;

   assign wired_in = (wdata > IN_W'(ENTRIES - 1)) ? TOP_IDX : wdata[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wired_q  <= '0;
         random_q <= TOP_IDX;
      end else begin
         if (wr_wired) wired_q <= wired_in;
         if (wr_wired || (random_q <= wired_q)) random_q <= TOP_IDX;
         else                                    random_q <= random_q - IDX_W'(1);
      end
   end

   assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (random_q >= wired_q) && (random_q <= TOP_IDX));

   assert_reload_on_wired_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_wired |=> (random_q == TOP_IDX));
endmodule

// File: rtl/cp0t_cause.sv
module cp0t_cause
   import cp0t_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit EXT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_irq,
   input  logic              timer_pend,
   output logic [DATA_W-1:0] cause,
   output logic              hw_irq
);
   if (DATA_W <= TIMER_BIT) begin : g_bad_data_w
      $error("cp0t_cause: DATA_W too narrow for the timer bit");
   end

   logic ext_q;

   if (EXT_REG) begin : g_ext_reg
      always_ff @(posedge clk) begin
         if (!rst_n) ext_q <= 1'b0;
         else        ext_q <= ext_irq;
      end

      assert_ext_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ext_irq |=> cause[EXT_BIT]);
      assert_ext_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !ext_irq |=> !cause[EXT_BIT]);
   end else begin : g_ext_comb
      assign ext_q = ext_irq;
   end

   always_comb begin
      cause            = '0;
      cause[TIMER_BIT] = timer_pend;
      cause[EXT_BIT]   = ext_q;
   end

   assign hw_irq = timer_pend | ext_q;
endmodule

// File: rtl/cp0_timer_unit.sv
module cp0_timer_unit
   import cp0t_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 32,
   parameter int TLB_ENTRIES = 48,
   parameter bit EXT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ext_irq,
   input  logic              wr_count,
   input  logic              wr_compare,
   input  logic              wr_wired,
   input  logic [DATA_W-1:0] wdata,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rdata,
   output logic              hw_irq
);
   localparam int IDX_W = $clog2(TLB_ENTRIES);

   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("cp0_timer_unit: CNT_W exceeds DATA_W");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx_w
      $error("cp0_timer_unit: index wider than DATA_W");
   end

   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  compare_q;
   logic              timer_pend;
   logic [IDX_W-1:0]  wired_q;
   logic [IDX_W-1:0]  random_q;
   logic [DATA_W-1:0] cause;

   cp0t_count_match #(.CNT_W(CNT_W)) i_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .wr_count   (wr_count),
      .wr_compare (wr_compare),
      .wdata      (wdata[CNT_W-1:0]),
      .count_q    (count_q),
      .compare_q  (compare_q),
      .timer_pend (timer_pend)
   );

   cp0t_rand_index #(.ENTRIES(TLB_ENTRIES), .IN_W(DATA_W), .IDX_W(IDX_W)) i_rand (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_wired (wr_wired),
      .wdata    (wdata),
      .wired_q  (wired_q),
      .random_q (random_q)
   );

   cp0t_cause #(.DATA_W(DATA_W), .EXT_REG(EXT_REG)) i_cause (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_irq    (ext_irq),
      .timer_pend (timer_pend),
      .cause      (cause),
      .hw_irq     (hw_irq)
   );

   always_comb begin
      case (rd_sel_e'(rd_sel))
         SEL_COUNT:   rdata = DATA_W'(count_q);
         SEL_COMPARE: rdata = DATA_W'(compare_q);
         SEL_CAUSE:   rdata = cause;
         SEL_WIRED:   rdata = DATA_W'(wired_q);
         SEL_RANDOM:  rdata = DATA_W'(random_q);
         default:     rdata = '0;
      endcase
   end

   assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_irq |-> (cause[TIMER_BIT] || cause[EXT_BIT]));
endmodule

// File: tb/test_cp0_timer_unit.sv
`timescale 1ns/100ps
module test_cp0_timer_unit;
   localparam int DW  = 32;
   localparam int CW  = 8;
   localparam int ENT = 8;
   localparam int TOP = ENT - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          ext_irq = 1'b0;
   logic          wr_count = 1'b0;
   logic          wr_compare = 1'b0;
   logic          wr_wired = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [2:0]    rd_sel = 3'd0;
   logic [DW-1:0] rdata;
   logic          hw_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cp0_timer_unit #(.DATA_W(DW), .CNT_W(CW), .TLB_ENTRIES(ENT)) i_cp0_timer_unit (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_irq(ext_irq),
      .wr_count(wr_count), .wr_compare(wr_compare), .wr_wired(wr_wired),
      .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .hw_irq(hw_irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] s, output logic [DW-1:0] v);
      rd_sel = s;
      #0.5;
      v = rdata;
   endtask

   task automatic wr(input int which, input logic [DW-1:0] v);
      wdata = v;
      wr_count   = (which == 0);
      wr_compare = (which == 1);
      wr_wired   = (which == 3);
      step();
      wr_count = 1'b0; wr_compare = 1'b0; wr_wired = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] c0;
      int model;
      step(); step();
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      rd(3'd0, v); chk("R1 count", v, 1);
      rd(3'd1, v); chk("R1 compare", v, 0);
      rd(3'd2, v); chk("R1 cause", v, 0);
      rd(3'd3, v); chk("R1 wired", v, 0);
      rd(3'd4, v); chk("R1 random", v, TOP);
      chk("R1 hw_irq", DW'(hw_irq), 0);

      // R2 hold without tick, then count ticks
      for (int i = 0; i < 5; i++) step();
      rd(3'd0, v); chk("R2 hold", v, 1);
      tick_en = 1'b1;
      for (int i = 0; i < 10; i++) step();
      tick_en = 1'b0;
      rd(3'd0, v); chk("R2 ten ticks", v, 11);

      // R3/R4 match by ticking
      wr(0, 10);
      rd(3'd0, v); chk("R3 count load", v, 10);
      rd(3'd1, v); chk("R3 compare untouched", v, 0);
      wr(1, 20);
      rd(3'd0, v); chk("R3 count after compare write", v, 10);
      tick_en = 1'b1;
      for (int i = 1; i <= 10; i++) begin
         step();
         if (i == 9) begin rd(3'd2, v); chk("R4 not yet", v, 0); end
      end
      rd(3'd2, v); chk("R4 match sets bit15", v, 32'h8000);
      chk("R7 irq on timer", DW'(hw_irq), 1);
      step(); step();
      tick_en = 1'b0;
      rd(3'd2, v); chk("R4 stays latched", v, 32'h8000);
      rd(3'd0, v); chk("R2 count 22", v, 22);
      wr(1, 100);
      rd(3'd2, v); chk("R5 compare write clears", v, 0);
      chk("R7 irq dropped", DW'(hw_irq), 0);
      rd(3'd1, v); chk("R3 compare loaded", v, 100);
      rd(3'd0, v); chk("R3 count unchanged", v, 22);

      // R3 compare write while running
      tick_en = 1'b1;
      wr(1, 50);
      tick_en = 1'b0;
      rd(3'd0, v); chk("R3 count keeps running", v, 23);

      // R4 stationary equality does not set
      wr(1, 23);
      for (int i = 0; i < 5; i++) step();
      rd(3'd2, v); chk("R4 stationary no set", v, 0);

      // R4 count write into equality sets
      wr(0, 5);
      wr(0, 23);
      rd(3'd2, v); chk("R4 count write match", v, 32'h8000);
      wr(1, 24);
      rd(3'd2, v); chk("R5 cleared", v, 0);

      // R5 simultaneous match and compare write
      tick_en = 1'b1;
      wr(1, 24);
      tick_en = 1'b0;
      rd(3'd0, v); chk("R5 count reached", v, 24);
      rd(3'd2, v); chk("R5 clear wins", v, 0);

      // R2 wrap with match across boundary
      wr(0, 250);
      wr(1, 2);
      tick_en = 1'b1;
      for (int i = 0; i < 8; i++) step();
      tick_en = 1'b0;
      rd(3'd0, v); chk("R2 wrap", v, 2);
      rd(3'd2, v); chk("R4 match after wrap", v, 32'h8000);
      wr(1, 32'h90);

      // R6/R7 external line
      ext_irq = 1'b1;
      rd(3'd2, v); chk("R6 one cycle latency", v, 0);
      step();
      rd(3'd2, v); chk("R6 bit10 set", v, 32'h400);
      chk("R7 irq on ext", DW'(hw_irq), 1);
      step();
      rd(3'd2, v); chk("R6 bit10 held", v, 32'h400);
      ext_irq = 1'b0;
      step();
      rd(3'd2, v); chk("R6 bit10 clear", v, 0);
      chk("R7 irq low", DW'(hw_irq), 0);

      // R10 unused select codes
      for (int s = 5; s < 8; s++) begin
         rd(3'(s), v); chk("R10 unused select", v, 0);
      end

      // R8/R9 every floor value
      for (int w = 0; w < ENT; w++) begin
         wr(3, DW'(w));
         rd(3'd3, v); chk("R9 wired stored", v, DW'(w));
         rd(3'd4, v); chk("R9 reload top", v, TOP);
         model = TOP;
         for (int k = 0; k < 2 * ENT; k++) begin
            step();
            model = (model <= w) ? TOP : model - 1;
            rd(3'd4, v); chk("R8 random sequence", v, DW'(model));
         end
      end

      // R9 clamp of oversized floor
      wr(3, 12);
      rd(3'd3, v); chk("R9 clamp", v, TOP);
      rd(3'd4, v); chk("R9 random top", v, TOP);
      step();
      rd(3'd4, v); chk("R8 pinned at top", v, TOP);

      c0 = 0;
      rd(3'd2, c0); chk("R7 cause quiet", c0, 0);
      done = 1'b1;
      finish_run();
   end
endmodule